// File: doc/BRIEF.md
# Shift-Register Multilinear Fold Engine

This block holds a table of N prime-field values and reduces it to a single value over log2(N) rounds. In each round one variable of the table's multilinear extension is fixed to a challenge r. Adjacent pairs (A[2s], A[2s+1]) are combined into (1 - r)·A[2s] + r·A[2s+1]. After the last round, the one remaining value is the multilinear extension evaluated at the point made of all the challenges. The first challenge binds the least significant index bit.

The storage is not a RAM. It is a shift register with a single write operator: one slot takes the new value, and every other slot takes the value two places above it. Only the two bottom slots are read. They feed a datapath of two multipliers and one adder, which produces one result per cycle. A serial port loads the table. Each round is started by a strobe that carries its challenge. A build-time option splits the table into two half-size registers that fold side by side. In that option, a final single-cycle combine step uses the last challenge.

Top module: `fold_engine`

## Requirements
- R1: After reset, busy_o, done_o, rd0_o, rd1_o and result_o are all zero.
- R2: While idle, each cycle with load_valid_i high shifts load_data_i into the table. After N loads, rd0_o shows the first value loaded and rd1_o shows the second. A load also clears done_o.
- R3: A start_i strobe while idle starts a round. busy_o rises on the next cycle and stays high for exactly L/2 cycles, where L is the current live length (N in the first round). Each of those cycles performs one write.
- R4: After the first round, rd0_o = (1-r)·A0 + r·A1 and rd1_o = (1-r)·A2 + r·A3 mod P. After log2(N) rounds with challenges r1, r2, r3, ..., done_o is high and result_o equals the sum over x of A[x]·Π_j (bit j-1 of x ? r_j : 1-r_j) mod P.
- R5: A start_i strobe while busy_o is high is ignored. The round in progress keeps the challenge it latched.
- R6: Slots filled from beyond the top of the register hold zero. Once done_o is high, rd1_o reads zero.
- R7: With the split option, the two halves (first N/2 loaded values and last N/2) fold independently. The last start then performs one combine cycle, (1-r)·low + r·high. result_o matches the unsplit result for the same challenges.
- R8: While done_o is high, start_i is ignored: busy_o stays low and result_o holds.
- R9: The arithmetic is modulo P. A challenge of 0 selects the even element of each pair, and a challenge of 1 selects the odd element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| load_valid_i | input | 1 | Shift one table value in |
| load_data_i | input | W | Table value, field element below P |
| start_i | input | 1 | Start a round with chal_i |
| chal_i | input | W | Round challenge, below P |
| busy_o | output | 1 | Round in progress |
| done_o | output | 1 | One value remains |
| rd0_o | output | W | Storage slot 0 (low half in split build) |
| rd1_o | output | W | Storage slot 1 (low half in split build) |
| result_o | output | W | Final folded value |

## Verification
A wrong write address or a broken shift-by-two corrupts the pair that sits at slots 0 and 1 on the very next step. This shows at rd0_o and rd1_o as soon as the first round ends, so the bench compares both against hand-folded values after round one. It compares the final value against a direct evaluation of the multilinear extension. A corrupted upper slot, or a missing zero fill, shows up later: either in the final value or in a nonzero rd1_o once done_o is high. Errors in round counting or in the ignore rules show up as a wrong busy_o length, or as a result that drifts after done_o.

// File: rtl/fold_pkg.sv
package fold_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_FOLD, PH_COMB} fold_phase_e;
endpackage

// File: rtl/fold_mac.sv
module fold_mac #(
  parameter int W = 16,
  parameter int P = 65521
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] r_i,
  output logic [W-1:0] y_o
);
  localparam int PW = 2 * W + 2;
  logic [PW-1:0] omr, prod_a, prod_b, sum;

  always_comb begin
    omr    = PW'(P) + PW'(1) - PW'(r_i);
    prod_a = omr * PW'(a_i);
    prod_b = PW'(r_i) * PW'(b_i);
    sum    = prod_a + prod_b;
    y_o    = W'(sum % PW'(P));
  end
endmodule

// File: rtl/fold_rwsr.sv
module fold_rwsr #(
  parameter int W  = 16,
  parameter int K  = 8,
  localparam int AW = (K > 1) ? $clog2(K) : 1
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          shift_en_i,
  input  logic [W-1:0]  shift_d_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_d_i,
  output logic [W-1:0]  slot0_o,
  output logic [W-1:0]  slot1_o
);
  logic [W-1:0] q [K];
  logic [W-1:0] d [K];

  for (genvar l = 0; l < K; l++) begin : g_slot
    logic [W-1:0] up2, up1;
    if (l + 2 < K) begin : g_u2
      assign up2 = q[l+2];
    end else begin : g_z2
      assign up2 = '0;
    end
    if (l + 1 < K) begin : g_u1
      assign up1 = q[l+1];
    end else begin : g_in
      assign up1 = shift_d_i;
    end

    always_comb begin
      if (wr_en_i) d[l] = (wr_addr_i == AW'(l)) ? wr_d_i : up2;
      else if (shift_en_i) d[l] = up1;
      else d[l] = q[l];
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) q[l] <= '0;
      else if (wr_en_i || shift_en_i) q[l] <= d[l];
    end
  end

  assign slot0_o = q[0];
  assign slot1_o = q[1];
endmodule

// File: rtl/fold_ctrl.sv
module fold_ctrl
  import fold_pkg::*;
#(
  parameter int W     = 16,
  parameter int LEN0  = 8,
  parameter bit SPLIT = 1'b0,
  localparam int LW = $clog2(LEN0) + 1,
  localparam int AW = (LEN0 > 1) ? $clog2(LEN0) : 1
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          load_i,
  input  logic          start_i,
  input  logic [W-1:0]  chal_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          comb_en_o,
  output logic [W-1:0]  r_o
);
  fold_phase_e ph_q, ph_d;
  logic [LW-1:0] len_q, len_d, step_q, step_d;
  logic [W-1:0]  r_q, r_d;
  logic          done_q, done_d;
  logic          last_step;

  assign last_step = (step_q == (len_q >> 1) - LW'(1));

  always_comb begin
    ph_d = ph_q; len_d = len_q; step_d = step_q; r_d = r_q; done_d = done_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (load_i) begin
          len_d  = LW'(LEN0);
          done_d = 1'b0;
        end else if (start_i && !done_q) begin
          r_d    = chal_i;
          step_d = '0;
          if (len_q > LW'(1)) ph_d = PH_FOLD;
          else if (SPLIT)     ph_d = PH_COMB;
        end
      end
      PH_FOLD: begin
        if (last_step) begin
          ph_d  = PH_IDLE;
          len_d = len_q >> 1;
          if (!SPLIT && len_q == LW'(2)) done_d = 1'b1;
        end else begin
          step_d = step_q + LW'(1);
        end
      end
      PH_COMB: begin
        ph_d   = PH_IDLE;
        done_d = 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ph_q   <= PH_IDLE;
      len_q  <= LW'(LEN0);
      step_q <= '0;
      r_q    <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      len_q  <= len_d;
      step_q <= step_d;
      r_q    <= r_d;
      done_q <= done_d;
    end
  end

  assign busy_o    = (ph_q != PH_IDLE);
  assign done_o    = done_q;
  assign wr_en_o   = (ph_q == PH_FOLD);
  assign comb_en_o = (ph_q == PH_COMB);
  assign wr_addr_o = AW'(len_q - LW'(2) - step_q);
  assign r_o       = r_q;
endmodule

// File: rtl/fold_engine.sv
module fold_engine #(
  parameter int W     = 16,
  parameter int P     = 65521,
  parameter int N     = 8,
  parameter bit SPLIT = 1'b0,
  localparam int LEN0 = SPLIT ? N / 2 : N,
  localparam int AW   = (LEN0 > 1) ? $clog2(LEN0) : 1
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         load_valid_i,
  input  logic [W-1:0] load_data_i,
  input  logic         start_i,
  input  logic [W-1:0] chal_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] rd0_o,
  output logic [W-1:0] rd1_o,
  output logic [W-1:0] result_o
);
  logic rst_s1, rst_sn;
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  logic          load_ok, wr_en, comb_en;
  logic [AW-1:0] wr_addr;
  logic [W-1:0]  r_cur;

  assign load_ok = load_valid_i && !busy_o;

  fold_ctrl #(.W(W), .LEN0(LEN0), .SPLIT(SPLIT)) u_ctrl (
    .clk_i(clk_i), .rst_n_i(rst_sn), .load_i(load_ok), .start_i(start_i),
    .chal_i(chal_i), .busy_o(busy_o), .done_o(done_o), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .comb_en_o(comb_en), .r_o(r_cur)
  );

  logic [W-1:0] lo0, lo1, lo_y;
  assign rd0_o = lo0;
  assign rd1_o = lo1;

  if (SPLIT) begin : g_split
    logic [W-1:0] hi0, hi1, hi_y, comb_y, res_q;

    fold_rwsr #(.W(W), .K(LEN0)) u_hi (
      .clk_i(clk_i), .rst_n_i(rst_sn), .shift_en_i(load_ok), .shift_d_i(load_data_i),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_d_i(hi_y), .slot0_o(hi0), .slot1_o(hi1)
    );
    fold_rwsr #(.W(W), .K(LEN0)) u_lo (
      .clk_i(clk_i), .rst_n_i(rst_sn), .shift_en_i(load_ok), .shift_d_i(hi0),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_d_i(lo_y), .slot0_o(lo0), .slot1_o(lo1)
    );
    fold_mac #(.W(W), .P(P)) u_mac_hi (.a_i(hi0), .b_i(hi1), .r_i(r_cur), .y_o(hi_y));
    fold_mac #(.W(W), .P(P)) u_mac_lo (.a_i(lo0), .b_i(lo1), .r_i(r_cur), .y_o(lo_y));
    fold_mac #(.W(W), .P(P)) u_mac_cb (.a_i(lo0), .b_i(hi0), .r_i(r_cur), .y_o(comb_y));

    always_ff @(posedge clk_i or negedge rst_sn) begin
      if (!rst_sn) res_q <= '0;
      else if (comb_en) res_q <= comb_y;
    end
    assign result_o = res_q;
  end else begin : g_single
    fold_rwsr #(.W(W), .K(LEN0)) u_lo (
      .clk_i(clk_i), .rst_n_i(rst_sn), .shift_en_i(load_ok), .shift_d_i(load_data_i),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_d_i(lo_y), .slot0_o(lo0), .slot1_o(lo1)
    );
    fold_mac #(.W(W), .P(P)) u_mac_lo (.a_i(lo0), .b_i(lo1), .r_i(r_cur), .y_o(lo_y));
    assign result_o = lo0;
  end
endmodule

// File: rtl/fold_engine_chk.sv
module fold_engine_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_n_i,
  input logic         load_valid_i,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] rd1_o,
  input logic [W-1:0] result_o
);
  // R4
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_o |-> !busy_o);

  // R6
  tail_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_o |-> (rd1_o == '0));

  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (done_o && !load_valid_i) |=> $stable(result_o));

  // R3
  busy_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(busy_o) |-> $past(start_i));

  // R8
  done_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (done_o && !load_valid_i) |=> !busy_o);
endmodule

bind fold_engine fold_engine_chk #(.W(W)) u_fold_chk (
  .clk_i(clk_i), .rst_n_i(rst_n_i), .load_valid_i(load_valid_i), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .rd1_o(rd1_o), .result_o(result_o)
);

// File: tb/test_fold_engine.sv
`timescale 1ns/1ps
module test_fold_engine;
  localparam int W = 16;
  localparam int P = 65521;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic load_valid, start;
  logic [W-1:0] load_data, chal;
  logic busy, done, busy_s, done_s;
  logic [W-1:0] rd0, rd1, res, rd0_s, rd1_s, res_s;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  longint vals [N];

  always #10 clk = ~clk;

  fold_engine #(.W(W), .P(P), .N(N), .SPLIT(1'b0)) i_fold_engine (
    .clk_i(clk), .rst_n_i(rst_n), .load_valid_i(load_valid), .load_data_i(load_data),
    .start_i(start), .chal_i(chal), .busy_o(busy), .done_o(done),
    .rd0_o(rd0), .rd1_o(rd1), .result_o(res)
  );
  fold_engine #(.W(W), .P(P), .N(N), .SPLIT(1'b1)) i_fold_engine_split (
    .clk_i(clk), .rst_n_i(rst_n), .load_valid_i(load_valid), .load_data_i(load_data),
    .start_i(start), .chal_i(chal), .busy_o(busy_s), .done_o(done_s),
    .rd0_o(rd0_s), .rd1_o(rd1_s), .result_o(res_s)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ffold(longint a, longint b, longint r);
    return ((P + 1 - r) * a + r * b) % P;
  endfunction

  function automatic longint mle(longint r1, longint r2, longint r3);
    longint acc = 0;
    longint rr [3];
    rr[0] = r1; rr[1] = r2; rr[2] = r3;
    for (int x = 0; x < N; x++) begin
      longint t = vals[x];
      for (int j = 0; j < 3; j++)
        t = (t * (((x >> j) & 1) != 0 ? rr[j] : (P + 1 - rr[j]) % P)) % P;
      acc = (acc + t) % P;
    end
    return acc;
  endfunction

  task automatic load_all();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      load_valid = 1'b1; load_data = W'(vals[i]);
    end
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  // Drives one round, returns busy cycle count of the unsplit instance.
  task automatic run_round(longint r, output int bcnt);
    @(negedge clk);
    start = 1'b1; chal = W'(r);
    @(negedge clk);
    start = 1'b0;
    bcnt = 0;
    while (busy || busy_s) begin
      if (busy) bcnt++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; load_valid = 1'b0; start = 1'b0; load_data = '0; chal = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 rd0", rd0, 0);
    check("R1 rd1", rd1, 0);
    check("R1 split result", res_s, 0);
  endtask

  task automatic t_full_fold();
    longint r1 = 1234, r2 = 60000, r3 = 777;
    int bc;
    for (int i = 0; i < N; i++) vals[i] = (i * 9871 + 17) % P;
    load_all();
    check("R2 rd0 first", rd0, vals[0]);
    check("R2 rd1 second", rd1, vals[1]);
    // round 1 with a second start while busy (must be ignored)
    @(negedge clk);
    start = 1'b1; chal = W'(r1);
    @(negedge clk);
    chal = W'(999);
    check("R3 busy rises", busy, 1);
    @(negedge clk);
    start = 1'b0;
    bc = 1;
    while (busy || busy_s) begin
      if (busy) bc++;
      @(negedge clk);
    end
    check("R3 busy length", bc, N / 2);
    check("R4 R5 rd0 after round1", rd0, ffold(vals[0], vals[1], r1));
    check("R4 R5 rd1 after round1", rd1, ffold(vals[2], vals[3], r1));
    run_round(r2, bc);
    check("R3 busy length round2", bc, N / 4);
    run_round(r3, bc);
    check("R4 done", done, 1);
    check("R4 result", res, mle(r1, r2, r3));
    check("R6 rd1 zero", rd1, 0);
    check("R7 split done", done_s, 1);
    check("R7 split result", res_s, mle(r1, r2, r3));
    // R8: start after done is ignored
    @(negedge clk);
    start = 1'b1; chal = W'(5);
    @(negedge clk);
    start = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R8 stays idle", busy | busy_s, 0);
    end
    check("R8 result held", res, mle(r1, r2, r3));
    check("R8 split result held", res_s, mle(r1, r2, r3));
  endtask

  task automatic t_select();
    int bc;
    for (int i = 0; i < N; i++) vals[i] = (i * 3001 + 5) % P;
    load_all();
    check("R2 done cleared", done, 0);
    run_round(0, bc);
    check("R9 r=0 picks even", rd0, vals[0]);
    run_round(1, bc);
    run_round(0, bc);
    check("R9 pick index 2", res, vals[2]);
    check("R9 split pick index 2", res_s, vals[2]);
  endtask

  task automatic t_random();
    for (int k = 0; k < 3; k++) begin
      longint ra, rb, rc;
      int bc;
      for (int i = 0; i < N; i++) vals[i] = $urandom % P;
      ra = $urandom % P; rb = $urandom % P; rc = $urandom % P;
      load_all();
      run_round(ra, bc);
      run_round(rb, bc);
      run_round(rc, bc);
      check("R4 random result", res, mle(ra, rb, rc));
      check("R7 random split result", res_s, mle(ra, rb, rc));
    end
  endtask

  initial begin
    t_reset();
    t_full_fold();
    t_select();
    t_random();
    summary();
    $finish;
  end
endmodule